// File: doc/BRIEF.md
# Flash Self-Programming Command Register

This block is the command register a small CPU core uses to program its own flash memory. The CPU writes one byte into the register. An enable bit in that byte selects which command is armed, together with at most one command bit. While the command is armed, the next store-to-program-memory strobe or load-from-program-memory strobe is steered to a flash-side action instead of its normal meaning. The actions are:
- write one word into the temporary page buffer
- clear that buffer
- erase a page
- write a page
- read a configuration byte or a signature byte

A command stays armed for only a few cycles. It drops by itself when that window expires, or once it has been used.

A page erase or page write halts the CPU. The halt lasts until the flash array reports completion. While the halt is active the register accepts no writes. When several command bits are written in the same byte, a fixed priority keeps exactly one of them.

Top module: `selfprog_ctrl`

## Requirements
- R1: After reset `reg_rdata` is 0. Bits 7 and 6 always read 0. The field layout is: bit 5 signature read, bit 4 buffer clear, bit 3 config read, bit 2 page write, bit 1 page erase, bit 0 enable.
- R2: A write with bit 0 set arms the enable bit and at most one command bit. If several command bits are set, the one at the lowest bit position is kept. A write with bit 0 clear arms nothing and disarms any armed command.
- R3: With only the enable bit armed, a store strobe pulses `buf_wr` in the same cycle. `buf_addr` is `zptr[6:1]` and `buf_data` is `src_word`. The register reads 0 from the next cycle on.
- R4: A write that arms page erase, page write, buffer clear or enable alone opens a window of 4 cycles after the write edge. A write that arms config read or signature read opens a window of 3 cycles. At the end of the window the register reads 0, and later strobes produce no command output.
- R5: A store strobe with page erase (or page write) armed starts the operation. From the next cycle `cpu_halt` and `pg_erase` (or `pg_write`) stay high, and `pg_addr` holds `zptr[15:7]` as it was at the strobe.
- R6: While an operation runs, `flash_done` ends it. From the next cycle `cpu_halt`, `pg_erase`, `pg_write` and `reg_rdata` are all 0.
- R7: Register writes made while `cpu_halt` is high have no effect on `reg_rdata`.
- R8: A load strobe with config read armed pulses `cfg_rd_sel` in the same cycle. `cfg_rd_lock` equals `zptr[0]` in that cycle (0 selects fuse bits, 1 selects lock bits). The command is then consumed.
- R9: A load strobe with signature read armed pulses `sig_rd_sel` and consumes the command. A store strobe in this window produces no output and leaves the command armed. The same holds for a store strobe with config read armed.
- R10: A store strobe with buffer clear armed pulses `buf_clr` and does not pulse `buf_wr`.
- R11: If a strobe consumes the armed command in the same cycle as a register write, the strobe acts and the write is dropped. A load strobe with a store-type command armed has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | CPU register write strobe |
| reg_wdata | input | 8 | CPU write data |
| reg_rdata | output | 8 | Register read value |
| st_strobe | input | 1 | Store-to-program-memory instruction strobe |
| ld_strobe | input | 1 | Load-from-program-memory instruction strobe |
| zptr | input | 16 | Z-pointer byte address |
| src_word | input | 16 | R1:R0 data word |
| flash_done | input | 1 | Flash array reports the page operation finished |
| buf_wr | output | 1 | Write a word into the temporary page buffer |
| buf_addr | output | 6 | Word index within the page buffer |
| buf_data | output | 16 | Word to write into the buffer |
| buf_clr | output | 1 | Clear the temporary page buffer |
| pg_erase | output | 1 | Page erase in progress |
| pg_write | output | 1 | Page write in progress |
| pg_addr | output | 9 | Page number of the running operation |
| cfg_rd_sel | output | 1 | Return a fuse or lock byte on this load |
| cfg_rd_lock | output | 1 | Lock byte (1) or fuse byte (0) for the config read |
| sig_rd_sel | output | 1 | Return a signature byte on this load |
| cpu_halt | output | 1 | Stall the CPU |

## Verification
The bench aims strobes at the last cycle of each window and at the first cycle after it. A design that counts the 3-cycle and 4-cycle windows wrongly either misses the final legal strobe or acts on a stale one.

It writes bytes with several command bits set and bytes with commands but no enable bit. A faulty priority encoder arms two commands, or arms the wrong one. A design that arms commands without the enable bit reads back non-zero.

It also issues the following, and checks that state and outputs do not move:
- writes during a halt
- store strobes inside a signature window
- load strobes with a store-type command armed
- strobes that coincide with a write

A design that mishandles any of these changes state or pulses an output where it must not.

// File: rtl/spc_pkg.sv
package spc_pkg;
    localparam int NCMD   = 5;
    // Command bit index inside the command field (register bit = index + 1)
    localparam int C_ERS  = 0;
    localparam int C_PWR  = 1;
    localparam int C_CFG  = 2;
    localparam int C_CLR  = 3;
    localparam int C_SIG  = 4;

    function automatic logic is_load_cmd(input logic [NCMD-1:0] c);
        return c[C_CFG] | c[C_SIG];
    endfunction
endpackage

// File: rtl/spc_cmd_pick.sv
module spc_cmd_pick #(
    parameter int N = 5
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] pick
);
    // Lowest set position wins
    for (genvar i = 0; i < N; i++) begin : g_pick
        if (i == 0) begin : g_first
            assign pick[i] = req[i];
        end else begin : g_rest
            assign pick[i] = req[i] & ~(|req[i-1:0]);
        end
    end
endmodule

// File: rtl/spc_win_timer.sv
module spc_win_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             stop,
    output logic             active,
    output logic             last
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)                    cnt_d = load_val;
        else if (stop)               cnt_d = '0;
        else if (cnt_q != '0)        cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign active = (cnt_q != '0);
    assign last   = (cnt_q == CNT_W'(1));

    AST_TMR_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && !load) |=> !active);                                    // R4
endmodule

// File: rtl/selfprog_ctrl.sv
module selfprog_ctrl #(
    parameter int Z_W      = 16,
    parameter int PG_OFS_W = 6,
    parameter int ST_WIN   = 4,
    parameter int LD_WIN   = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      reg_we,
    input  logic [7:0]                reg_wdata,
    output logic [7:0]                reg_rdata,
    input  logic                      st_strobe,
    input  logic                      ld_strobe,
    input  logic [Z_W-1:0]            zptr,
    input  logic [15:0]               src_word,
    input  logic                      flash_done,
    output logic                      buf_wr,
    output logic [PG_OFS_W-1:0]       buf_addr,
    output logic [15:0]               buf_data,
    output logic                      buf_clr,
    output logic                      pg_erase,
    output logic                      pg_write,
    output logic [Z_W-PG_OFS_W-2:0]   pg_addr,
    output logic                      cfg_rd_sel,
    output logic                      cfg_rd_lock,
    output logic                      sig_rd_sel,
    output logic                      cpu_halt
);
    import spc_pkg::*;

    localparam int PG_W  = Z_W - PG_OFS_W - 1;
    localparam int WMAX  = (ST_WIN > LD_WIN) ? ST_WIN : LD_WIN;
    localparam int CNT_W = $clog2(WMAX + 1);

    typedef struct packed {
        logic [NCMD-1:0] cmd;
        logic            en;
        logic            busy;
        logic [PG_W-1:0] pg;
    } ctl_t;

    ctl_t st_d, st_q;

    logic [NCMD-1:0]  picked;
    logic             tmr_load, tmr_stop, tmr_active, tmr_last;
    logic [CNT_W-1:0] tmr_val;
    logic             armed, st_hit, ld_hit, load_type;
    logic             use_st, use_ld;
    logic             unused_wbits;

    assign unused_wbits = ^reg_wdata[7:6];

    spc_cmd_pick #(.N(NCMD)) u_pick (
        .req  (reg_wdata[NCMD:1]),
        .pick (picked)
    );

    spc_win_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .stop     (tmr_stop),
        .active   (tmr_active),
        .last     (tmr_last)
    );

    // Strobe qualification
    assign armed     = st_q.en & tmr_active & ~st_q.busy;
    assign st_hit    = st_strobe & armed;
    assign ld_hit    = ld_strobe & armed;
    assign load_type = is_load_cmd(st_q.cmd);
    assign use_st    = st_hit & ~load_type;
    assign use_ld    = ld_hit &  load_type;

    always_comb begin
        st_d     = st_q;
        tmr_load = 1'b0;
        tmr_stop = 1'b0;
        tmr_val  = CNT_W'(ST_WIN);
        if (st_q.busy) begin
            if (flash_done) begin
                st_d     = '0;
                tmr_stop = 1'b1;
            end
        end else if (use_st) begin
            tmr_stop = 1'b1;
            if (st_q.cmd[C_ERS] | st_q.cmd[C_PWR]) begin
                st_d.busy = 1'b1;
                st_d.pg   = zptr[Z_W-1:PG_OFS_W+1];
            end else begin
                st_d = '0;
            end
        end else if (use_ld) begin
            st_d     = '0;
            tmr_stop = 1'b1;
        end else if (reg_we) begin
            if (reg_wdata[0]) begin
                st_d.cmd = picked;
                st_d.en  = 1'b1;
                tmr_load = 1'b1;
                tmr_val  = is_load_cmd(picked) ? CNT_W'(LD_WIN) : CNT_W'(ST_WIN);
            end else begin
                st_d     = '0;
                tmr_stop = 1'b1;
            end
        end else if (tmr_last) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign reg_rdata   = {2'b00, st_q.cmd, st_q.en};
    assign buf_wr      = use_st & (st_q.cmd == '0);
    assign buf_addr    = zptr[PG_OFS_W:1];
    assign buf_data    = src_word;
    assign buf_clr     = use_st & st_q.cmd[C_CLR];
    assign cfg_rd_sel  = use_ld & st_q.cmd[C_CFG];
    assign cfg_rd_lock = cfg_rd_sel & zptr[0];
    assign sig_rd_sel  = use_ld & st_q.cmd[C_SIG];
    assign pg_erase    = st_q.busy & st_q.cmd[C_ERS];
    assign pg_write    = st_q.busy & st_q.cmd[C_PWR];
    assign pg_addr     = st_q.pg;
    assign cpu_halt    = st_q.busy;

    AST_ONE_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(reg_rdata[NCMD:1]));                                    // R2
    AST_CMD_HAS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[NCMD:1] != '0) |-> reg_rdata[0]);                     // R2
    AST_BUFWR_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        buf_wr |-> (reg_rdata == 8'h01) && !cpu_halt);                   // R3
    AST_HALT_FROM_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_halt) |-> $past(st_strobe));                           // R5
    AST_HALT_HAS_OP: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_halt |-> (pg_erase ^ pg_write));                             // R5
    AST_DONE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_halt && flash_done) |=> (!cpu_halt && reg_rdata == 8'h00)); // R6
    AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_halt && !flash_done) |=> $stable(reg_rdata));               // R7
endmodule

// File: tb/selfprog_ctrl_tb.sv
module selfprog_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        st_strobe = 1'b0, ld_strobe = 1'b0;
    logic [15:0] zptr = '0, src_word = '0;
    logic        flash_done = 1'b0;
    logic        buf_wr, buf_clr, pg_erase, pg_write, cfg_rd_sel, cfg_rd_lock, sig_rd_sel, cpu_halt;
    logic [5:0]  buf_addr;
    logic [15:0] buf_data;
    logic [8:0]  pg_addr;

    always #5 clk = ~clk;

    selfprog_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .st_strobe(st_strobe), .ld_strobe(ld_strobe), .zptr(zptr), .src_word(src_word),
        .flash_done(flash_done), .buf_wr(buf_wr), .buf_addr(buf_addr), .buf_data(buf_data),
        .buf_clr(buf_clr), .pg_erase(pg_erase), .pg_write(pg_write), .pg_addr(pg_addr),
        .cfg_rd_sel(cfg_rd_sel), .cfg_rd_lock(cfg_rd_lock), .sig_rd_sel(sig_rd_sel),
        .cpu_halt(cpu_halt)
    );

    int n_tests = 0, n_fail = 0;

    // Reference model state: cmd[0]=erase,1=pgwrite,2=cfg,3=clr,4=sig
    logic [4:0] m_cmd = '0;
    logic       m_en = 1'b0, m_busy = 1'b0;
    int         m_cnt = 0;
    logic [8:0] m_pg = '0;

    task automatic chk(string req, string nm, int act, int exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, nm, act, exp);
        end
    endtask

    function automatic logic [4:0] lowest(input logic [4:0] r);
        for (int i = 0; i < 5; i++) if (r[i]) return 5'(1 << i);
        return '0;
    endfunction

    task automatic clr_model();
        m_cmd = '0; m_en = 1'b0; m_busy = 1'b0; m_cnt = 0;
    endtask

    // One cycle: drive, check combinational and state outputs, advance model
    task automatic cyc(input logic we, input logic [7:0] wd, input logic st, input logic ld,
                       input logic [15:0] z, input logic [15:0] d, input logic done);
        logic armed, sth, ldh, ldc;
        reg_we = we; reg_wdata = wd; st_strobe = st; ld_strobe = ld;
        zptr = z; src_word = d; flash_done = done;
        #2;
        armed = m_en && (m_cnt != 0) && !m_busy;
        sth = st && armed; ldh = ld && armed;
        ldc = m_cmd[2] | m_cmd[4];
        chk("R1", "reg_rdata", reg_rdata, {2'b00, m_cmd, m_en});
        chk("R3", "buf_wr", buf_wr, sth && !ldc && m_cmd == 0);
        if (buf_wr) begin
            chk("R3", "buf_addr", buf_addr, z[6:1]);
            chk("R3", "buf_data", buf_data, d);
        end
        chk("R10", "buf_clr", buf_clr, sth && m_cmd[3]);
        chk("R8", "cfg_rd_sel", cfg_rd_sel, ldh && m_cmd[2]);
        chk("R8", "cfg_rd_lock", cfg_rd_lock, ldh && m_cmd[2] && z[0]);
        chk("R9", "sig_rd_sel", sig_rd_sel, ldh && m_cmd[4]);
        chk("R5", "pg_erase", pg_erase, m_busy && m_cmd[0]);
        chk("R5", "pg_write", pg_write, m_busy && m_cmd[1]);
        chk("R6", "cpu_halt", cpu_halt, m_busy);
        if (m_busy) chk("R5", "pg_addr", pg_addr, m_pg);
        @(posedge clk);
        if (m_busy) begin
            if (done) clr_model();
        end else if (sth && !ldc) begin
            if (m_cmd[0] | m_cmd[1]) begin m_busy = 1'b1; m_pg = z[15:7]; m_cnt = 0; end
            else clr_model();
        end else if (ldh && ldc) begin
            clr_model();
        end else if (we) begin
            if (wd[0]) begin
                m_cmd = lowest(wd[5:1]); m_en = 1'b1;
                m_cnt = (m_cmd[2] | m_cmd[4]) ? 3 : 4;
            end else clr_model();
        end else if (m_cnt == 1) begin
            clr_model();
        end else if (m_cnt > 0) begin
            m_cnt--;
        end
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 16'h1234, 16'h0, 0);
    endtask

    initial begin
        #(200000 * 10);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        chk("R1", "reset rdata", reg_rdata, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R3: enable alone, buffer store on the last window cycle
        cyc(1, 8'h01, 0, 0, 0, 0, 0);
        idle(3);
        cyc(0, 0, 1, 0, 16'h0046, 16'hBEEF, 0);
        idle(1);
        // R4: store strobe one cycle late has no effect
        cyc(1, 8'h01, 0, 0, 0, 0, 0);
        idle(4);
        cyc(0, 0, 1, 0, 16'h0002, 16'h1111, 0);
        // R4/R8: load window of 3 cycles, late then on-time
        cyc(1, 8'h09, 0, 0, 0, 0, 0);
        idle(3);
        cyc(0, 0, 0, 1, 16'h0001, 0, 0);
        cyc(1, 8'h09, 0, 0, 0, 0, 0);
        idle(2);
        cyc(0, 0, 0, 1, 16'h0001, 0, 0);
        // R2: priority and missing enable
        cyc(1, 8'h3F, 0, 0, 0, 0, 0);
        cyc(1, 8'hFE, 0, 0, 0, 0, 0);
        cyc(1, 8'h35, 0, 0, 0, 0, 0);
        // R5/R7/R6: page write, writes ignored while halted, done
        cyc(1, 8'h05, 0, 0, 0, 0, 0);
        cyc(0, 0, 1, 0, 16'hABCD, 0, 0);
        cyc(1, 8'h03, 0, 0, 0, 0, 0);
        cyc(1, 8'h00, 0, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 0, 1);
        idle(1);
        // R9: signature store ignored, load consumes
        cyc(1, 8'h21, 0, 0, 0, 0, 0);
        cyc(0, 0, 1, 0, 0, 0, 0);
        cyc(0, 0, 0, 1, 0, 0, 0);
        // R10: buffer clear; R11: strobe beats write, load with erase armed
        cyc(1, 8'h11, 0, 0, 0, 0, 0);
        cyc(1, 8'h03, 1, 0, 0, 0, 0);
        cyc(1, 8'h03, 0, 0, 0, 0, 0);
        cyc(0, 0, 0, 1, 0, 0, 0);
        cyc(0, 0, 1, 0, 16'hFF80, 0, 0);
        cyc(0, 0, 0, 0, 0, 0, 1);
        // Random phase
        for (int i = 0; i < 4000; i++) begin
            logic [7:0] w;
            w = 8'($urandom);
            w[0] = ($urandom % 4) != 0;
            cyc(($urandom % 4) == 0, w, ($urandom % 3) == 0, ($urandom % 3) == 0,
                16'($urandom), 16'($urandom), ($urandom % 6) == 0);
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule